// File: doc/BRIEF.md
# Lane-Based 64-bit Carry-less Multiplier

This block forms the full 128-bit carry-less product (multiplication of two polynomials over GF(2)) of two 64-bit operands. It has no 64x64 array. It holds one bank of eight 8x8 carry-less lane multipliers and uses that bank over eight passes. Each pass feeds the bank byte-rotated copies of the operands. The sixteen-bit lane products are then moved to their byte offset. A lane whose rotation wrapped past the top byte is folded back down by 64 bits, and the result is XORed into an accumulator.

The passes run in a fixed order. The first pass uses the operands as given. Each rotation distance k from one byte to three bytes then takes two passes: the second operand rotated right by k bytes, then the first operand rotated right by k bytes. The last pass rotates the second operand by four bytes. Together the passes cover every pairing of a byte of one operand with a byte of the other exactly once.

The control is a three-state machine:
- IDLE waits with `in_ready` high. It moves to RUN when `in_valid` is seen; this is the accept transition.
- RUN performs one pass per cycle. It moves to DONE after the eighth pass.
- DONE shows `out_valid` for one cycle and always returns to IDLE.

Top module: `lane_clmul64`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_prod` is all zeros.
- R2: For any operands, bit n of `out_prod` equals the XOR over all i+j=n of `in_a[i] & in_b[j]`, using the operands captured at acceptance.
- R3: `out_valid` is high for exactly one cycle. It rises on the 8th rising clock edge after the accepting edge, whatever the operand values.
- R4: `in_ready` is 0 from the accepting edge until `out_valid` has been shown. While it is 0, `in_valid` and the operand inputs have no effect on the result and start no extra operation. `in_ready` is 1 again in the cycle after `out_valid`.
- R5: `out_prod` keeps the last result while the block is idle with no new operand accepted.
- R6: Equal operands give their square: bit 2i of `out_prod` equals operand bit i, and every odd bit is 0.
- R7: Bit 127 of `out_prod` is always 0 when `out_valid` is high.
- R8: Single-bit operands with bit i in `in_a` and bit j in `in_b` give exactly one set bit, at position i+j. This includes the wrap-around lanes and the highest case, i=j=63, which gives bit 126.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Block idle and able to accept operands |
| in_a | input | 64 | First operand polynomial |
| in_b | input | 64 | Second operand polynomial |
| out_valid | output | 1 | One-cycle pulse marking a finished product |
| out_prod | output | 128 | Carry-less product, held until the next acceptance |

## Verification
The assertions assume that the environment does not drop `in_valid` for a reason the block must see. They rely only on the block's own transitions: an offer made while `in_ready` is low is treated as noise, not as a protocol error.

The stimulus drives operands on the falling edge and raises `in_valid` only when `in_ready` is seen high. It deliberately drives different operands with `in_valid` high during a run, to show they are ignored. It then lowers `in_valid` before the edge that returns the block to IDLE, so the latency and hold checks are never disturbed by an unplanned acceptance.

// File: rtl/lane_clmul_pkg.sv
package lane_clmul_pkg;

    localparam int unsigned LANE_W_DEF = 8;
    localparam int unsigned LANES_DEF  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } clm_state_t;

endpackage

// File: rtl/clm_lane.sv
module clm_lane #(
    parameter int unsigned LW = 8
) (
    input  logic [LW-1:0]   op_x,
    input  logic [LW-1:0]   op_y,
    output logic [2*LW-1:0] prod
);
    // Shift-and-XOR product of two LW-bit polynomials.
    always_comb begin
        prod = '0;
        for (int i = 0; i < LW; i++) begin
            if (op_y[i]) begin
                prod = prod ^ ({{LW{1'b0}}, op_x} << i);
            end
        end
    end
endmodule

// File: rtl/clm_lane_bank.sv
module clm_lane_bank #(
    parameter int unsigned LW    = 8,
    parameter int unsigned LANES = 8
) (
    input  logic [LANES*LW-1:0]          vec_x,
    input  logic [LANES*LW-1:0]          vec_y,
    output logic [LANES-1:0][2*LW-1:0]   lane_prod
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        clm_lane #(.LW(LW)) u_lane (
            .op_x (vec_x[g*LW +: LW]),
            .op_y (vec_y[g*LW +: LW]),
            .prod (lane_prod[g])
        );
    end
endmodule

// File: rtl/clm_align.sv
module clm_align #(
    parameter int unsigned LW    = 8,
    parameter int unsigned LANES = 8,
    parameter int unsigned KW    = 4
) (
    input  logic [LANES-1:0][2*LW-1:0] lane_prod,
    input  logic [KW-1:0]              rot,
    output logic [2*LANES*LW-1:0]      placed
);
    localparam int unsigned OP_W = LANES * LW;
    localparam int unsigned PW   = 2 * OP_W;

    // Lane i holds byte i of one operand times byte (i+rot) mod LANES of the other.
    // Its natural offset is 2*LW*i + LW*rot bits. A lane that wrapped lands one
    // full operand width too high, so it is folded down by OP_W.
    int sh;
    always_comb begin
        placed = '0;
        sh     = 0;
        for (int i = 0; i < LANES; i++) begin
            sh = 2 * LW * i + LW * int'(rot);
            if (i + int'(rot) >= LANES) begin
                sh = sh - OP_W;
            end
            placed = placed ^ ({{(PW - 2*LW){1'b0}}, lane_prod[i]} << sh);
        end
    end
endmodule

// File: rtl/lane_clmul64.sv
module lane_clmul64
    import lane_clmul_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned LANES  = LANES_DEF   // must be even
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [LANE_W*LANES-1:0]     in_a,
    input  logic [LANE_W*LANES-1:0]     in_b,
    output logic                        out_valid,
    output logic [2*LANE_W*LANES-1:0]   out_prod
);
    localparam int unsigned OP_W  = LANE_W * LANES;
    localparam int unsigned PW    = 2 * OP_W;
    localparam int unsigned NPASS = LANES;
    localparam int unsigned PCW   = $clog2(NPASS);
    localparam int unsigned KW    = PCW + 1;
    localparam int unsigned LCW   = PCW + 2;

    clm_state_t state_q, state_d;

    logic [OP_W-1:0]  a_q, b_q;
    logic [PCW-1:0]   pass_q;
    logic [PW-1:0]    acc_q;
    logic             accept;
    logic             last_pass;

    assign accept    = (state_q == ST_IDLE) && in_valid;
    assign last_pass = (pass_q == PCW'(NPASS - 1));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_RUN;
            ST_RUN:  if (last_pass) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_RUN:  ;
            ST_DONE: out_valid = 1'b1;
            default: ;
        endcase
    end

    assign out_prod = acc_q;

    // ---------------- pass schedule ----------------
    // pass 0: (A,B); odd pass p: (A, B>>>k); even pass p>0: (A>>>k, B); k=(p+1)/2.
    function automatic logic [OP_W-1:0] rotr_bytes(input logic [OP_W-1:0] x,
                                                   input logic [KW-1:0]   k);
        logic [2*OP_W-1:0] d;
        d = {x, x} >> (LANE_W * k);
        return d[OP_W-1:0];
    endfunction

    logic [KW-1:0]   rot;
    logic [OP_W-1:0] feed_a, feed_b;

    assign rot    = KW'(({1'b0, pass_q} + 1'b1) >> 1);
    assign feed_a = (pass_q != '0 && !pass_q[0]) ? rotr_bytes(a_q, rot) : a_q;
    assign feed_b = pass_q[0] ? rotr_bytes(b_q, rot) : b_q;

    logic [LANES-1:0][2*LANE_W-1:0] lane_prod;
    logic [PW-1:0]                  placed;

    clm_lane_bank #(.LW(LANE_W), .LANES(LANES)) u_bank (
        .vec_x     (feed_a),
        .vec_y     (feed_b),
        .lane_prod (lane_prod)
    );

    clm_align #(.LW(LANE_W), .LANES(LANES), .KW(KW)) u_align (
        .lane_prod (lane_prod),
        .rot       (rot),
        .placed    (placed)
    );

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            pass_q <= '0;
            acc_q  <= '0;
        end else if (accept) begin
            a_q    <= in_a;
            b_q    <= in_b;
            pass_q <= '0;
            acc_q  <= '0;
        end else if (state_q == ST_RUN) begin
            acc_q  <= acc_q ^ placed;
            pass_q <= pass_q + 1'b1;
        end
    end

    // ---------------- assertions ----------------
    logic [LCW-1:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  lat_cnt <= '0;
        else if (accept)             lat_cnt <= '0;
        else if (state_q != ST_IDLE) lat_cnt <= lat_cnt + 1'b1;
    end

    // R3
    latency_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_cnt == LCW'(NPASS)));

    // R4
    ready_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (in_ready && !out_valid));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(out_prod));

    // R6
    square_odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (a_q == b_q)) |->
            ((out_prod & {OP_W{2'b10}}) == '0));

    // R7
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_prod[PW-1]);

endmodule

// File: tb/lane_clmul64_bench.sv
module lane_clmul64_bench;

    localparam time CLK_P = 8ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [63:0]   in_a = '0;
    logic [63:0]   in_b = '0;
    logic          in_ready;
    logic          out_valid;
    logic [127:0]  out_prod;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lane_clmul64 u_lane_clmul64 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    function automatic logic [127:0] ref_clmul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] r = '0;
        for (int i = 0; i < 64; i++)
            if (b[i]) r = r ^ ({64'b0, a} << i);
        return r;
    endfunction

    function automatic logic [127:0] ref_square(input logic [63:0] a);
        logic [127:0] r = '0;
        for (int i = 0; i < 64; i++) r[2*i] = a[i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation; junk=1 keeps offering other operands while busy (R4).
    task automatic do_mul(input logic [63:0] a, input logic [63:0] b,
                          input string tag, input bit junk);
        logic [127:0] exp;
        bit           early;
        bit           rdy_seen;
        logic [127:0] got;
        exp = ref_clmul(a, b);
        @(negedge clk);
        chk(in_ready === 1'b1, "R4 ready idle", {127'b0, in_ready}, 128'd1);
        in_a = a; in_b = b; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (junk) begin
            in_a = ~a; in_b = b ^ 64'h5a5a_0ff0_1234_8001;
        end else begin
            in_valid = 1'b0;
        end
        early    = out_valid;
        rdy_seen = in_ready;
        for (int c = 1; c <= 8; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c < 8) begin
                early    = early | out_valid;
                rdy_seen = rdy_seen | in_ready;
            end
        end
        in_valid = 1'b0;
        chk(!early && out_valid === 1'b1, "R3 latency",
            {126'b0, early, out_valid}, 128'd1);
        if (junk)
            chk(!rdy_seen, "R4 busy not ready", {127'b0, rdy_seen}, 128'd0);
        chk(out_prod === exp, tag, out_prod, exp);
        chk(out_prod[127] === 1'b0, "R7 msb", {127'b0, out_prod[127]}, 128'd0);
        got = out_prod;
        @(posedge clk);
        @(negedge clk);
        chk(!out_valid && in_ready, "R3 one-cycle pulse / R4 ready back",
            {126'b0, out_valid, in_ready}, 128'd1);
        chk(out_prod === got, "R5 hold", out_prod, got);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] ra, rb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 flags",
            {126'b0, in_ready, out_valid}, 128'd2);
        chk(out_prod === '0, "R1 product", out_prod, '0);
        rst_n = 1'b1;

        // R2 corners
        do_mul('0, '0, "R2 zeros", 1'b0);
        do_mul('1, '0, "R2 ones x zero", 1'b0);
        do_mul('1, '1, "R2 ones x ones", 1'b0);
        do_mul(64'h8000_0000_0000_0001, '1, "R2 ends x ones", 1'b0);

        // R8 exhaustive single-bit sweep
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
                do_mul(64'd1 << i, 64'd1 << j, "R8 single bits", 1'b0);

        // R6 squares
        for (int s = 0; s < 40; s++) begin
            ra = {$urandom, $urandom};
            do_mul(ra, ra, "R6 square", 1'b0);
            chk(out_prod === ref_square(ra), "R6 interleave", out_prod, ref_square(ra));
        end
        do_mul('1, '1, "R6 square ones", 1'b0);
        chk(out_prod === {64{2'b01}}, "R6 interleave ones", out_prod, {64{2'b01}});

        // R2 random operands
        for (int s = 0; s < 200; s++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            do_mul(ra, rb, "R2 random", 1'b0);
        end

        // R4 inputs offered while busy are ignored
        for (int s = 0; s < 20; s++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            do_mul(ra, rb, "R4 busy offers ignored", 1'b1);
        end

        // R5 hold over a long idle stretch
        do_mul(64'hdead_beef_0123_4567, 64'h0f0f_f0f0_8421_1248, "R2 pattern", 1'b0);
        ra = out_prod[63:0];
        repeat (20) @(negedge clk);
        chk(out_prod === ref_clmul(64'hdead_beef_0123_4567, 64'h0f0f_f0f0_8421_1248),
            "R5 long hold", out_prod,
            ref_clmul(64'hdead_beef_0123_4567, 64'h0f0f_f0f0_8421_1248));
        chk(out_valid === 1'b0, "R3 no spurious valid", {127'b0, out_valid}, 128'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule